// File: doc/BRIEF.md
# Time-over-Threshold Pixel Column Readout

This block is the digital back end of one column of a triggerless hybrid pixel readout chip. Every cell watches its own discriminator output, already sampled into the core clock domain. When the output goes high, the cell copies a free-running time stamp from a bus that all cells share. When the output goes low, the cell copies the stamp a second time. The gap between the two stamps is the time over threshold, and it gives the deposited charge. A cell that holds both stamps has a complete hit, and the column raises `busy` while any complete hit is still unread.

A column controller always selects the lowest-numbered cell that holds a complete hit. On a `read_lead` command it sends that cell's leading stamp out. On a `read_trail` command it sends the trailing stamp together with the time over threshold, and then releases the cell. The result leaves through a valid/ready output stage, which holds a word until the consumer takes it. A command only takes effect when a complete hit exists and the output stage is empty or being drained in that same cycle. A command that arrives at any other time is dropped, not queued, so the sender must repeat it. While `cfg_phase` is high, the stamp bus carries configuration words instead of time stamps. Each word is written into the cell chosen by `cfg_sel`, and that word sets the cell's mask bit and its threshold trim code.

Top module: `tot_column_readout`

## Requirements
- R1: After reset, `out_valid`, `busy` and `overflow` are 0, and every trim code on `trim_codes` is 0.
- R2: An unmasked cell copies `ts` into its leading register at the first clock edge where its `comp` bit is 1 after being 0. It copies `ts` into its trailing register at the first edge where `comp` is 0 after being 1. The hit becomes complete at the trailing capture, and from the next cycle `busy` is 1.
- R3: An accepted `read_lead` makes `out_valid` 1 in the next cycle, with `out_data` = leading stamp, `out_addr` = cell index and `out_trail` = 0. The cell keeps its hit.
- R4: An accepted `read_trail` makes `out_valid` 1 in the next cycle, with `out_data` = trailing stamp, `out_trail` = 1 and `out_tot` = (trailing − leading) mod 4096. The cell's hit is then cleared.
- R5: When several cells hold complete hits, the lowest cell index is served first.
- R6: While `out_valid` is 1 and `out_ready` is 0, the output word stays unchanged, and any command in that cycle is ignored. `out_valid` falls after a cycle with `out_ready` = 1 in which no command is accepted.
- R7: Bit 5 of a cell's configuration word is its mask. A masked cell records no hits.
- R8: When `cfg_phase` and `cfg_wr` are both 1 at an edge, `ts` is written into the configuration register of cell `cfg_sel`. Bits [4:0] of that register appear on `trim_codes[5*i +: 5]`. No edge is captured while `cfg_phase` is 1.
- R9: While `freeze` is 1, rising edges start no new hits. A hit whose leading edge came before the freeze still completes when its trailing edge arrives.
- R10: A rising edge on a cell that already holds a complete unread hit is dropped. The stored stamps stay unchanged, and the sticky `overflow` output becomes 1 and stays 1 until reset.
- R11: A command given when no complete hit exists produces no output. If `read_lead` and `read_trail` arrive together, the command is treated as `read_lead`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| comp | input | NCELLS | synchronised discriminator outputs, bit i = cell i |
| ts | input | 12 | shared time stamp, or configuration word while cfg_phase is 1 |
| cfg_phase | input | 1 | configuration phase, hit capture disabled |
| cfg_wr | input | 1 | configuration write strobe |
| cfg_sel | input | 7 | cell to configure |
| freeze | input | 1 | blocks new hits |
| read_lead | input | 1 | request leading stamp of selected cell |
| read_trail | input | 1 | request trailing stamp of selected cell and release it |
| out_ready | input | 1 | consumer accepts the output word |
| out_valid | output | 1 | output word is present |
| out_data | output | 12 | stamp value |
| out_addr | output | 7 | cell index |
| out_trail | output | 1 | 1 for a trailing-stamp word |
| out_tot | output | 12 | time over threshold, valid with trailing words |
| busy | output | 1 | some complete hit remains unread |
| overflow | output | 1 | sticky: a hit was dropped |
| trim_codes | output | NCELLS*5 | per-cell threshold trim codes |

## Verification
The bench places leading and trailing stamps on either side of the counter wrap. A design that subtracts without modulo arithmetic would report a huge time over threshold instead of 11. It raises a second rising edge on a cell that holds an unread hit and then reads the cell back. A design that overwrites the stored stamps, or that forgets the sticky flag, shows a wrong trailing value or a low `overflow`. It issues a trailing read while the output stage is stalled. A design that queued the command or dropped the held word would lose a hit or change the data, and one that released the cell early would clear `busy`. It also checks freeze against an open hit, configuration-phase blocking, masking, and arbitration between two pending cells.

// File: rtl/tot_pkg.sv
package tot_pkg;
  localparam int TRIM_W   = 5;
  localparam int MASK_BIT = 5;

  typedef enum logic {
    KIND_LEAD  = 1'b0,
    KIND_TRAIL = 1'b1
  } rd_kind_e;
endpackage

// File: rtl/tot_pixel_cell.sv
module tot_pixel_cell
  import tot_pkg::*;
#(
  parameter int TS_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                comp,
  input  logic [TS_W-1:0]     ts,
  input  logic                cfg_phase,
  input  logic                cfg_wr,
  input  logic                freeze,
  input  logic                clr,
  output logic [TS_W-1:0]     lead_q,
  output logic [TS_W-1:0]     trail_q,
  output logic                full,
  output logic                drop,
  output logic [TRIM_W-1:0]   trim
);
  logic            comp_q;
  logic            open_q;
  logic [TS_W-1:0] cfg_q;
  logic            cap_en, rise, fall;

  assign cap_en = !cfg_phase && !cfg_q[MASK_BIT];
  assign rise   = comp && !comp_q;
  assign fall   = !comp && comp_q;
  assign drop   = cap_en && rise && !freeze && full;
  assign trim   = cfg_q[TRIM_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q  <= 1'b0;
      open_q  <= 1'b0;
      full    <= 1'b0;
      lead_q  <= '0;
      trail_q <= '0;
      cfg_q   <= '0;
    end else begin
      comp_q <= comp;
      if (cfg_phase && cfg_wr) cfg_q <= ts;
      if (clr) full <= 1'b0;
      if (cap_en) begin
        if (rise && !freeze && !full && !open_q) begin
          lead_q <= ts;
          open_q <= 1'b1;
        end
        if (fall && open_q) begin
          trail_q <= ts;
          open_q  <= 1'b0;
          full    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tot_prio_enc.sv
module tot_prio_enc #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tot_readout_ctrl.sv
module tot_readout_ctrl
  import tot_pkg::*;
#(
  parameter int TS_W   = 12,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_any,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [TS_W-1:0]   sel_lead,
  input  logic [TS_W-1:0]   sel_trail,
  input  logic              read_lead,
  input  logic              read_trail,
  input  logic              out_ready,
  output logic              release_sel,
  output logic              out_valid,
  output logic [TS_W-1:0]   out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_trail,
  output logic [TS_W-1:0]   out_tot
);
  logic     accept;
  rd_kind_e kind;

  assign accept      = sel_any && (read_lead || read_trail) && (!out_valid || out_ready);
  assign kind        = read_lead ? KIND_LEAD : KIND_TRAIL;
  assign release_sel = accept && (kind == KIND_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= '0;
      out_trail <= 1'b0;
      out_tot   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= sel_addr;
      out_trail <= (kind == KIND_TRAIL);
      out_data  <= (kind == KIND_TRAIL) ? sel_trail : sel_lead;
      out_tot   <= sel_trail - sel_lead;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tot_column_readout.sv
module tot_column_readout
  import tot_pkg::*;
#(
  parameter int NCELLS = 32,
  parameter int TS_W   = 12,
  parameter int ADDR_W = 7,
  localparam int IW    = $clog2(NCELLS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCELLS-1:0]        comp,
  input  logic [TS_W-1:0]          ts,
  input  logic                     cfg_phase,
  input  logic                     cfg_wr,
  input  logic [ADDR_W-1:0]        cfg_sel,
  input  logic                     freeze,
  input  logic                     read_lead,
  input  logic                     read_trail,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [TS_W-1:0]          out_data,
  output logic [ADDR_W-1:0]        out_addr,
  output logic                     out_trail,
  output logic [TS_W-1:0]          out_tot,
  output logic                     busy,
  output logic                     overflow,
  output logic [NCELLS*TRIM_W-1:0] trim_codes
);
  logic [TS_W-1:0]   lead_arr  [NCELLS];
  logic [TS_W-1:0]   trail_arr [NCELLS];
  logic [NCELLS-1:0] full_vec, drop_vec, clr_vec;
  logic              sel_any, release_sel;
  logic [IW-1:0]     sel_idx;

  for (genvar g = 0; g < NCELLS; g++) begin : g_cell
    tot_pixel_cell #(.TS_W(TS_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .comp      (comp[g]),
      .ts        (ts),
      .cfg_phase (cfg_phase),
      .cfg_wr    (cfg_wr && (cfg_sel == ADDR_W'(g))),
      .freeze    (freeze),
      .clr       (clr_vec[g]),
      .lead_q    (lead_arr[g]),
      .trail_q   (trail_arr[g]),
      .full      (full_vec[g]),
      .drop      (drop_vec[g]),
      .trim      (trim_codes[g*TRIM_W +: TRIM_W])
    );
    assign clr_vec[g] = release_sel && (sel_idx == IW'(g));
  end

  tot_prio_enc #(.N(NCELLS)) u_enc (
    .req (full_vec),
    .any (sel_any),
    .idx (sel_idx)
  );

  tot_readout_ctrl #(.TS_W(TS_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_any     (sel_any),
    .sel_addr    (ADDR_W'(sel_idx)),
    .sel_lead    (lead_arr[sel_idx]),
    .sel_trail   (trail_arr[sel_idx]),
    .read_lead   (read_lead),
    .read_trail  (read_trail),
    .out_ready   (out_ready),
    .release_sel (release_sel),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_addr    (out_addr),
    .out_trail   (out_trail),
    .out_tot     (out_tot)
  );

  assign busy = |full_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          overflow <= 1'b0;
    else if (|drop_vec)  overflow <= 1'b1;
  end
endmodule

// File: rtl/tot_column_checker.sv
module tot_column_checker #(
  parameter int TS_W   = 12,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_phase,
  input logic              read_lead,
  input logic              read_trail,
  input logic              out_ready,
  input logic              out_valid,
  input logic [TS_W-1:0]   out_data,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_trail,
  input logic              busy,
  input logic              overflow
);
  // R6: a stalled word holds still
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr) && $stable(out_trail));

  // R6: drained with no command means empty
  a_r6_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && !read_lead && !read_trail |=> !out_valid);

  // R10: overflow is sticky
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8: no hit completes during configuration
  a_r8_no_capture_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_phase |=> !$rose(busy));

  // R11: no complete hit means no output
  a_r11_idle_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (!out_valid || out_ready) |=> !out_valid);

  // R4: accepted trailing read yields a trailing word
  a_r4_trail_word: assert property (@(posedge clk) disable iff (!rst_n)
    busy && read_trail && !read_lead && (!out_valid || out_ready) |=> out_valid && out_trail);
endmodule

bind tot_column_readout tot_column_checker #(.TS_W(TS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_phase  (cfg_phase),
  .read_lead  (read_lead),
  .read_trail (read_trail),
  .out_ready  (out_ready),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_addr   (out_addr),
  .out_trail  (out_trail),
  .busy       (busy),
  .overflow   (overflow)
);

// File: tb/tot_column_readout_test.sv
`timescale 1ns/1ps
module tot_column_readout_test;
  localparam int NC = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] comp = '0;
  logic [11:0]   ts = '0;
  logic          cfg_phase = 1'b0, cfg_wr = 1'b0, freeze = 1'b0;
  logic [6:0]    cfg_sel = '0;
  logic          read_lead = 1'b0, read_trail = 1'b0, out_ready = 1'b0;
  logic          out_valid, out_trail, busy, overflow;
  logic [11:0]   out_data, out_tot;
  logic [6:0]    out_addr;
  logic [NC*5-1:0] trim_codes;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tot_column_readout #(.NCELLS(NC)) uut (
    .clk(clk), .rst_n(rst_n), .comp(comp), .ts(ts), .cfg_phase(cfg_phase),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .freeze(freeze), .read_lead(read_lead),
    .read_trail(read_trail), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_addr(out_addr), .out_trail(out_trail),
    .out_tot(out_tot), .busy(busy), .overflow(overflow), .trim_codes(trim_codes)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hit(int c, logic [11:0] a, logic [11:0] b);
    ts = a; comp[c] = 1'b1; step();
    ts = b; comp[c] = 1'b0; step();
  endtask

  // issue a command, check the word, then drain it
  task automatic rd(bit trail, string req, int addr, logic [11:0] data);
    read_lead = !trail; read_trail = trail; out_ready = 1'b0; step();
    read_lead = 1'b0; read_trail = 1'b0;
    check({req, " valid"}, out_valid, 1);
    check({req, " addr"}, out_addr, addr);
    check({req, " data"}, out_data, data);
    check({req, " kind"}, out_trail, trail);
    out_ready = 1'b1; step(); out_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", out_valid, 0);
    check("R1 busy", busy, 0);
    check("R1 overflow", overflow, 0);
    check("R1 trim", trim_codes[31:0], 0);
  endtask

  task automatic t_basic_wrap();
    hit(5, 12'd4090, 12'd5);
    check("R2 busy after trailing edge", busy, 1);
    rd(1'b0, "R3 lead", 5, 12'd4090);
    check("R3 cell kept", busy, 1);
    rd(1'b1, "R4 trail", 5, 12'd5);
    check("R4 tot wrap", out_tot, 12'd11);
    check("R4 released", busy, 0);
  endtask

  task automatic t_priority();
    hit(20, 12'h100, 12'h180);
    hit(6, 12'h200, 12'h230);
    rd(1'b1, "R5 first", 6, 12'h230);
    check("R5 tot", out_tot, 12'h030);
    rd(1'b1, "R5 second", 20, 12'h180);
    check("R5 empty", busy, 0);
  endtask

  task automatic t_backpressure();
    hit(9, 12'h011, 12'h022);
    read_lead = 1'b1; out_ready = 1'b0; step();
    read_lead = 1'b0; read_trail = 1'b1; step();
    read_trail = 1'b0;
    check("R6 held valid", out_valid, 1);
    check("R6 held data", out_data, 12'h011);
    check("R6 held kind", out_trail, 0);
    check("R6 stalled cmd ignored", busy, 1);
    out_ready = 1'b1; step(); out_ready = 1'b0;
    check("R6 drained", out_valid, 0);
    rd(1'b1, "R6 retry", 9, 12'h022);
  endtask

  task automatic t_mask_cfg();
    cfg_phase = 1'b1; cfg_wr = 1'b1; cfg_sel = 7'd2; ts = 12'h03A; step();
    cfg_wr = 1'b0;
    check("R8 trim written", trim_codes[2*5 +: 5], 5'h1A);
    check("R8 neighbour trim", trim_codes[3*5 +: 5], 5'h00);
    hit(4, 12'h050, 12'h060);
    check("R8 no capture in cfg phase", busy, 0);
    cfg_phase = 1'b0; step();
    hit(2, 12'h070, 12'h080);
    check("R7 masked cell silent", busy, 0);
    cfg_phase = 1'b1; cfg_wr = 1'b1; ts = 12'h000; step();
    cfg_wr = 1'b0; cfg_phase = 1'b0; step();
    hit(2, 12'h090, 12'h0A0);
    check("R7 unmasked again", busy, 1);
    rd(1'b1, "R7 read", 2, 12'h0A0);
  endtask

  task automatic t_freeze();
    ts = 12'h300; comp[7] = 1'b1; step();
    freeze = 1'b1;
    ts = 12'h310; comp[8] = 1'b1; step();
    ts = 12'h340; comp[7] = 1'b0; comp[8] = 1'b0; step();
    check("R9 open hit completes", busy, 1);
    rd(1'b1, "R9 read", 7, 12'h340);
    check("R9 frozen hit absent", busy, 0);
    freeze = 1'b0; step();
  endtask

  task automatic t_overflow();
    hit(3, 12'h400, 12'h444);
    check("R10 no overflow yet", overflow, 0);
    hit(3, 12'h500, 12'h555);
    check("R10 overflow set", overflow, 1);
    rd(1'b1, "R10 stamps kept", 3, 12'h444);
    check("R10 lead kept", out_tot, 12'h044);
    step();
    check("R10 sticky", overflow, 1);
  endtask

  task automatic t_empty_and_both();
    read_lead = 1'b1; step(); read_lead = 1'b0;
    check("R11 no word when empty", out_valid, 0);
    hit(12, 12'h600, 12'h612);
    read_lead = 1'b1; read_trail = 1'b1; step();
    read_lead = 1'b0; read_trail = 1'b0;
    check("R11 both gives lead kind", out_trail, 0);
    check("R11 both gives lead data", out_data, 12'h600);
    check("R11 both keeps cell", busy, 1);
    out_ready = 1'b1; step(); out_ready = 1'b0;
    rd(1'b1, "R11 cleanup", 12, 12'h612);
  endtask

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1; step();
    t_basic_wrap();
    t_priority();
    t_backpressure();
    t_mask_cfg();
    t_freeze();
    t_overflow();
    t_empty_and_both();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule